// File: doc/BRIEF.md
# Fixed-Point Dataflow Operation Unit

This block is a purely combinational operator that evaluates one node of a quantized dataflow graph. Parameters fixed at elaboration choose the operation and the number format of each operand. A format is a sign flag, an integer bit count and a fractional bit count, and the operand width is the sum of the three. A format whose three fields are all zero is a zero-width operand.

The unit takes two data operands and a single-bit key, and produces one result truncated to an output width. The result is the exact arithmetic outcome taken modulo 2^OUT_W. Operands are lined up by their fractional bit counts before they are combined. A negative operation code means the same operation with one operand negated first. An operation code outside the supported set stops elaboration with an error.

Top module: `fxp_op_unit`

## Requirements
- R1: With OPCODE 0, y_o equals A + B·2^s, reduced modulo 2^OUT_W. Here s = SHIFT + A_F − B_F. When s < 0 the result is A·2^−s + B instead. A and B are the operand codes, read as two's complement when signed.
- R2: With OPCODE 1, y_o equals A − B·2^s (or A·2^−s − B when s < 0), reduced modulo 2^OUT_W, with s defined as in R1.
- R3: With OPCODE 2, let L = A_F − OUT_F. y_o is floor(A / 2^L) modulo 2^OUT_W, and 0 whenever the operand is signed and negative.
- R4: With OPCODE 3, y_o is floor(A / 2^L) modulo 2^OUT_W. Positions above the operand MSB are filled with its sign (zero if unsigned). A negative L appends −L zero bits.
- R5: OPCODEs −2 and −3 apply the R3 and R4 rules to −A, computed without overflow.
- R6: With OPCODE 4, y_o equals A + C·2^t (or A·2^−t + C when t < 0), reduced modulo 2^OUT_W. C is CONST_VAL and t = A_F − OUT_F.
- R7: With OPCODE 5, y_o is CONST_VAL in two's complement at OUT_W bits, whatever the inputs.
- R8: With OPCODE 6, key_i = 1 selects A·2^max(0,−m) and key_i = 0 selects B·2^max(0,m), each reduced modulo 2^OUT_W. Here m = A_F − B_F + X, where X is MUX_CFG[63:32] read as a signed 32-bit value. MUX_CFG[31:0] has no effect.
- R9: With OPCODE −6, the key_i = 0 path gives the negation of the aligned B. The key_i = 1 path is as in R8.
- R10: A zero-width mux data operand acts as a single 0 bit: the a_i pin is ignored and the key_i = 1 path yields 0.
- R11: With OPCODE 7, y_o is A·B modulo 2^OUT_W. Mixed signedness is handled by treating the unsigned operand as non-negative.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | max(A_W,1) | First data operand code |
| b_i | input | max(B_W,1) | Second data operand code |
| key_i | input | 1 | Selector for the mux operations |
| y_o | output | OUT_W | Result in the output format |

## Verification
The cases hardest to reach are the ones where the unit must extend an operand beyond its own MSB. These include a negated most-negative input, a requantization slice that sits entirely above the operand, and a negative mux shift that moves the selected operand instead of the other one. Fifteen instances with hand-chosen formats put each of these cases in reach of the shared input pins. Fixed corner codes (all ones, only the sign bit set, zero, one) then drive them before a random sweep. The zero-width instance receives random bits on its ignored pin, so any leak shows up at y_o.

// File: rtl/fxp_pkg.sv
package fxp_pkg;
  localparam int OP_ADD   = 0;
  localparam int OP_SUB   = 1;
  localparam int OP_RELU  = 2;
  localparam int OP_QUANT = 3;
  localparam int OP_CADD  = 4;
  localparam int OP_CONST = 5;
  localparam int OP_MUX   = 6;
  localparam int OP_MUL   = 7;

  function automatic int imax(input int x, input int y);
    return (x > y) ? x : y;
  endfunction
endpackage

// File: rtl/fxp_ext.sv
// Sign/zero extend, shift left, keep OUT_W bits.
module fxp_ext import fxp_pkg::*; #(
  parameter int IN_W  = 4,
  parameter bit IN_S  = 1'b0,
  parameter int LSH   = 0,
  parameter int OUT_W = 8,
  localparam int XW   = imax(IN_W + LSH, OUT_W)
) (
  input  logic [IN_W-1:0]  d_i,
  output logic [OUT_W-1:0] q_o
);
  if (IN_S) begin : g_sgn
    assign q_o = OUT_W'(XW'($signed(d_i)) << LSH);
  end else begin : g_uns
    assign q_o = OUT_W'(XW'(d_i) << LSH);
  end
endmodule

// File: rtl/fxp_addsub.sv
module fxp_addsub import fxp_pkg::*; #(
  parameter int A_W   = 4,
  parameter bit A_S   = 1'b0,
  parameter int B_W   = 4,
  parameter bit B_S   = 1'b0,
  parameter int SH    = 0,
  parameter bit SUB   = 1'b0,
  parameter int OUT_W = 8,
  localparam int LA   = (SH < 0) ? -SH : 0,
  localparam int LB   = (SH > 0) ? SH : 0,
  // carry + guard for subtract + guard for mixed sign
  localparam int GW   = imax(A_W + LA, B_W + LB) + 1 + int'(SUB) + ((A_S != B_S) ? 1 : 0),
  localparam int WW   = imax(GW, OUT_W)
) (
  input  logic [A_W-1:0]   a_i,
  input  logic [B_W-1:0]   b_i,
  output logic [OUT_W-1:0] y_o
);
  logic [WW-1:0] xa_w, xb_w;

  fxp_ext #(.IN_W(A_W), .IN_S(A_S), .LSH(LA), .OUT_W(WW)) u_xa (.d_i(a_i), .q_o(xa_w));
  fxp_ext #(.IN_W(B_W), .IN_S(B_S), .LSH(LB), .OUT_W(WW)) u_xb (.d_i(b_i), .q_o(xb_w));

  if (SUB) begin : g_sub
    assign y_o = OUT_W'(xa_w - xb_w);
  end else begin : g_add
    assign y_o = OUT_W'(xa_w + xb_w);
  end
endmodule

// File: rtl/fxp_slice.sv
// Requantize by bit slicing, optional negate-first and ReLU.
module fxp_slice import fxp_pkg::*; #(
  parameter int IN_W  = 4,
  parameter bit IN_S  = 1'b0,
  parameter int OFS   = 0,
  parameter int OUT_W = 4,
  parameter bit NEG   = 1'b0,
  parameter bit RELU  = 1'b0,
  localparam int SW   = NEG ? IN_W + 1 : IN_W,
  localparam bit SS   = NEG ? 1'b1 : IN_S,
  localparam int LSH  = (OFS < 0) ? -OFS : 0,
  localparam int R    = (OFS > 0) ? OFS : 0,
  localparam int EW   = imax(SW + LSH, R + OUT_W)
) (
  input  logic [IN_W-1:0]  d_i,
  output logic [OUT_W-1:0] y_o
);
  logic [SW-1:0]    src_w;
  logic [EW-1:0]    ext_w;
  logic [OUT_W-1:0] sl_w;

  if (NEG) begin : g_neg
    logic [SW-1:0] wide_w;
    fxp_ext #(.IN_W(IN_W), .IN_S(IN_S), .LSH(0), .OUT_W(SW)) u_wide (.d_i(d_i), .q_o(wide_w));
    assign src_w = -wide_w;
  end else begin : g_pos
    assign src_w = d_i;
  end

  fxp_ext #(.IN_W(SW), .IN_S(SS), .LSH(LSH), .OUT_W(EW)) u_ext (.d_i(src_w), .q_o(ext_w));
  assign sl_w = OUT_W'(ext_w >> R);

  if (RELU && SS) begin : g_relu
    assign y_o = src_w[SW-1] ? '0 : sl_w;
  end else begin : g_pass
    assign y_o = sl_w;
  end
endmodule

// File: rtl/fxp_mul.sv
module fxp_mul import fxp_pkg::*; #(
  parameter int A_W   = 4,
  parameter bit A_S   = 1'b0,
  parameter int B_W   = 4,
  parameter bit B_S   = 1'b0,
  parameter int OUT_W = 8,
  localparam int PW   = A_W + B_W + 1,
  localparam int WW   = imax(PW, OUT_W)
) (
  input  logic [A_W-1:0]   a_i,
  input  logic [B_W-1:0]   b_i,
  output logic [OUT_W-1:0] y_o
);
  logic [WW-1:0] xa_w, xb_w;

  // unsigned operand zero-extended: behaves as non-negative in signed product
  fxp_ext #(.IN_W(A_W), .IN_S(A_S), .LSH(0), .OUT_W(WW)) u_xa (.d_i(a_i), .q_o(xa_w));
  fxp_ext #(.IN_W(B_W), .IN_S(B_S), .LSH(0), .OUT_W(WW)) u_xb (.d_i(b_i), .q_o(xb_w));

  assign y_o = OUT_W'(xa_w * xb_w);
endmodule

// File: rtl/fxp_op_unit.sv
module fxp_op_unit import fxp_pkg::*; #(
  parameter int          OPCODE    = OP_ADD,
  parameter bit          A_S       = 1'b1,
  parameter int          A_I       = 3,
  parameter int          A_F       = 2,
  parameter bit          B_S       = 1'b1,
  parameter int          B_I       = 2,
  parameter int          B_F       = 1,
  parameter int          OUT_W     = 9,
  parameter int          OUT_F     = 0,
  parameter int          SHIFT     = 1,
  parameter int          CONST_VAL = 0,
  parameter logic [63:0] MUX_CFG   = 64'd0,
  localparam int A_W  = int'(A_S) + A_I + A_F,
  localparam int B_W  = int'(B_S) + B_I + B_F,
  localparam int A_PW = (A_W > 0) ? A_W : 1,
  localparam int B_PW = (B_W > 0) ? B_W : 1
) (
  input  logic [A_PW-1:0]  a_i,
  input  logic [B_PW-1:0]  b_i,
  input  logic             key_i,
  output logic [OUT_W-1:0] y_o
);

  if (OPCODE == OP_ADD || OPCODE == OP_SUB) begin : g_addsub
    logic unused_w;
    assign unused_w = key_i;
    fxp_addsub #(
      .A_W(A_PW), .A_S(A_S), .B_W(B_PW), .B_S(B_S),
      .SH(SHIFT + A_F - B_F), .SUB(OPCODE == OP_SUB), .OUT_W(OUT_W)
    ) u_addsub (.a_i(a_i), .b_i(b_i), .y_o(y_o));

  end else if (OPCODE == OP_RELU || OPCODE == -OP_RELU ||
               OPCODE == OP_QUANT || OPCODE == -OP_QUANT) begin : g_slice
    logic unused_w;
    assign unused_w = ^{b_i, key_i};
    fxp_slice #(
      .IN_W(A_PW), .IN_S(A_S), .OFS(A_F - OUT_F), .OUT_W(OUT_W),
      .NEG(OPCODE < 0), .RELU(OPCODE == OP_RELU || OPCODE == -OP_RELU)
    ) u_slice (.d_i(a_i), .y_o(y_o));

  end else if (OPCODE == OP_CADD) begin : g_cadd
    localparam int CMAG = (CONST_VAL < 0) ? -CONST_VAL : CONST_VAL;
    localparam int CW   = (CMAG > 1) ? $clog2(CMAG + 1) : 1;
    logic          unused_w;
    logic [CW-1:0] c_w;
    assign unused_w = ^{b_i, key_i};
    assign c_w      = CW'(CMAG);
    // magnitude into the adder, subtract when the constant is negative
    fxp_addsub #(
      .A_W(A_PW), .A_S(A_S), .B_W(CW), .B_S(1'b0),
      .SH(A_F - OUT_F), .SUB(CONST_VAL < 0), .OUT_W(OUT_W)
    ) u_cadd (.a_i(a_i), .b_i(c_w), .y_o(y_o));

  end else if (OPCODE == OP_CONST) begin : g_const
    logic unused_w;
    assign unused_w = ^{a_i, b_i, key_i};
    assign y_o      = OUT_W'(CONST_VAL);

  end else if (OPCODE == OP_MUX || OPCODE == -OP_MUX) begin : g_mux
    localparam int MX  = int'(signed'(MUX_CFG[63:32]));
    localparam int MSH = A_F - B_F + MX;
    localparam int MLA = (MSH < 0) ? -MSH : 0;
    localparam int MLB = (MSH > 0) ? MSH : 0;
    localparam int MGW = imax(A_PW + MLA, B_PW + MLB) + 2;
    localparam int MWW = imax(MGW, OUT_W);
    logic [A_PW-1:0] as_w;
    logic [MWW-1:0]  xa_w, xb_w, pb_w;

    if (A_W == 0) begin : g_za
      logic unused_w;
      assign unused_w = a_i[0];
      assign as_w     = 1'b0;
    end else begin : g_a
      assign as_w = a_i;
    end

    fxp_ext #(.IN_W(A_PW), .IN_S(A_S && (A_W > 0)), .LSH(MLA), .OUT_W(MWW))
      u_xa (.d_i(as_w), .q_o(xa_w));
    fxp_ext #(.IN_W(B_PW), .IN_S(B_S && (B_W > 0)), .LSH(MLB), .OUT_W(MWW))
      u_xb (.d_i(b_i), .q_o(xb_w));

    if (OPCODE < 0) begin : g_inv
      assign pb_w = -xb_w;
    end else begin : g_fwd
      assign pb_w = xb_w;
    end

    assign y_o = key_i ? OUT_W'(xa_w) : OUT_W'(pb_w);

  end else if (OPCODE == OP_MUL) begin : g_mul
    logic unused_w;
    assign unused_w = key_i;
    fxp_mul #(.A_W(A_PW), .A_S(A_S), .B_W(B_PW), .B_S(B_S), .OUT_W(OUT_W))
      u_mul (.a_i(a_i), .b_i(b_i), .y_o(y_o));

  end else begin : g_bad
    $error("fxp_op_unit: unsupported OPCODE %0d", OPCODE);
    logic unused_w;
    assign unused_w = ^{a_i, b_i, key_i};
    assign y_o      = '0;
  end

endmodule

// File: rtl/fxp_op_unit_chk.sv
module fxp_op_unit_chk import fxp_pkg::*; #(
  parameter int          OPCODE    = OP_ADD,
  parameter bit          A_S       = 1'b1,
  parameter int          A_I       = 3,
  parameter int          A_F       = 2,
  parameter bit          B_S       = 1'b1,
  parameter int          B_I       = 2,
  parameter int          B_F       = 1,
  parameter int          OUT_W     = 9,
  parameter int          SHIFT     = 1,
  parameter logic [63:0] MUX_CFG   = 64'd0,
  localparam int A_W  = int'(A_S) + A_I + A_F,
  localparam int B_W  = int'(B_S) + B_I + B_F,
  localparam int A_PW = (A_W > 0) ? A_W : 1,
  localparam int B_PW = (B_W > 0) ? B_W : 1,
  localparam int SH   = SHIFT + A_F - B_F,
  localparam int LA   = (SH < 0) ? -SH : 0,
  localparam int MSH  = A_F - B_F + int'(signed'(MUX_CFG[63:32])),
  localparam int MLA  = (MSH < 0) ? -MSH : 0
) (
  input logic [A_PW-1:0]  a_i,
  input logic [B_PW-1:0]  b_i,
  input logic             key_i,
  input logic [OUT_W-1:0] y_o
);
  logic [63:0] ax_w;
  always_comb ax_w = A_S ? 64'($signed(a_i)) : 64'(a_i);

  always_comb begin
    if (!$isunknown({a_i, b_i, key_i, y_o})) begin
      // R1
      if (OPCODE == OP_ADD && b_i == '0)
        add_zero_chk: assert (y_o == OUT_W'(ax_w << LA));
      // R3
      if (OPCODE == OP_RELU && A_S && a_i[A_PW-1])
        relu_neg_chk: assert (y_o == '0);
      // R5
      if (OPCODE == -OP_RELU && (!A_S || !a_i[A_PW-1]))
        neg_relu_chk: assert (y_o == '0);
      // R8
      if ((OPCODE == OP_MUX || OPCODE == -OP_MUX) && A_W > 0 && key_i)
        mux_key_chk: assert (y_o == OUT_W'(ax_w << MLA));
      // R9
      if (OPCODE == -OP_MUX && !key_i && b_i == '0)
        nmux_zero_chk: assert (y_o == '0);
      // R10
      if (OPCODE == OP_MUX && A_W == 0 && key_i)
        zero_width_chk: assert (y_o == '0);
      // R11
      if (OPCODE == OP_MUL && a_i == '0)
        mul_zero_chk: assert (y_o == '0);
    end
  end
endmodule

bind fxp_op_unit fxp_op_unit_chk #(
  .OPCODE(OPCODE), .A_S(A_S), .A_I(A_I), .A_F(A_F),
  .B_S(B_S), .B_I(B_I), .B_F(B_F), .OUT_W(OUT_W),
  .SHIFT(SHIFT), .MUX_CFG(MUX_CFG)
) chk_i (.a_i(a_i), .b_i(b_i), .key_i(key_i), .y_o(y_o));

// File: tb/fxp_op_unit_tb_top.sv
module fxp_op_unit_tb_top;
  localparam int HALF = 2;  // 4-unit period: 250 MHz at 1 ns per unit
  localparam int NID  = 15;

  logic       clk = 1'b0;
  logic [7:0] a_r = '0;
  logic [7:0] b_r = '0;
  logic       key_r = 1'b0;
  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #HALF clk = ~clk;

  typedef struct {
    int          id;
    logic [31:0] exp;
    logic [7:0]  a;
    logic [7:0]  b;
    logic        k;
  } item_t;
  item_t sb_q[$];

  logic [8:0] y0;  logic [7:0] y1;  logic [4:0] y2;  logic [5:0] y3;
  logic [5:0] y4;  logic [3:0] y5;  logic [4:0] y6;  logic [6:0] y7;
  logic [7:0] y8;  logic [5:0] y9;  logic [7:0] y10; logic [5:0] y11;
  logic [4:0] y12; logic [6:0] y13; logic [4:0] y14;

  // add: s = 1 + 2 - 1 = 2
  fxp_op_unit #(.OPCODE(0), .A_S(1), .A_I(3), .A_F(2), .B_S(1), .B_I(2), .B_F(1),
    .OUT_W(9), .SHIFT(1)) dut_i (.a_i(a_r[5:0]), .b_i(b_r[3:0]), .key_i(key_r), .y_o(y0));
  // sub: s = 0 - 2 = -2
  fxp_op_unit #(.OPCODE(1), .A_S(0), .A_I(4), .A_F(0), .B_S(1), .B_I(2), .B_F(2),
    .OUT_W(8), .SHIFT(0)) u_sub (.a_i(a_r[3:0]), .b_i(b_r[4:0]), .key_i(key_r), .y_o(y1));
  fxp_op_unit #(.OPCODE(2), .A_S(1), .A_I(4), .A_F(3), .B_S(0), .B_I(1), .B_F(0),
    .OUT_W(5), .OUT_F(1)) u_relu (.a_i(a_r), .b_i(b_r[0]), .key_i(key_r), .y_o(y2));
  fxp_op_unit #(.OPCODE(3), .A_S(1), .A_I(2), .A_F(1), .B_S(0), .B_I(1), .B_F(0),
    .OUT_W(6), .OUT_F(0)) u_rq (.a_i(a_r[3:0]), .b_i(b_r[0]), .key_i(key_r), .y_o(y3));
  fxp_op_unit #(.OPCODE(3), .A_S(0), .A_I(3), .A_F(0), .B_S(0), .B_I(1), .B_F(0),
    .OUT_W(6), .OUT_F(2)) u_rq_up (.a_i(a_r[2:0]), .b_i(b_r[0]), .key_i(key_r), .y_o(y4));
  fxp_op_unit #(.OPCODE(-2), .A_S(1), .A_I(3), .A_F(2), .B_S(0), .B_I(1), .B_F(0),
    .OUT_W(4), .OUT_F(1)) u_nrelu (.a_i(a_r[5:0]), .b_i(b_r[0]), .key_i(key_r), .y_o(y5));
  fxp_op_unit #(.OPCODE(-3), .A_S(1), .A_I(3), .A_F(0), .B_S(0), .B_I(1), .B_F(0),
    .OUT_W(5), .OUT_F(0)) u_nrq (.a_i(a_r[3:0]), .b_i(b_r[0]), .key_i(key_r), .y_o(y6));
  fxp_op_unit #(.OPCODE(4), .A_S(1), .A_I(3), .A_F(1), .B_S(0), .B_I(1), .B_F(0),
    .OUT_W(7), .OUT_F(0), .CONST_VAL(-5)) u_cadd (.a_i(a_r[4:0]), .b_i(b_r[0]), .key_i(key_r), .y_o(y7));
  fxp_op_unit #(.OPCODE(4), .A_S(0), .A_I(4), .A_F(0), .B_S(0), .B_I(1), .B_F(0),
    .OUT_W(8), .OUT_F(2), .CONST_VAL(3)) u_cadd2 (.a_i(a_r[3:0]), .b_i(b_r[0]), .key_i(key_r), .y_o(y8));
  fxp_op_unit #(.OPCODE(5), .A_S(0), .A_I(2), .A_F(0), .B_S(0), .B_I(1), .B_F(0),
    .OUT_W(6), .CONST_VAL(-3)) u_const (.a_i(a_r[1:0]), .b_i(b_r[0]), .key_i(key_r), .y_o(y9));
  // mux: m = 1 - 0 + 1 = 2, key index field set to 7
  fxp_op_unit #(.OPCODE(6), .A_S(1), .A_I(3), .A_F(1), .B_S(0), .B_I(3), .B_F(0),
    .OUT_W(8), .MUX_CFG({32'd1, 32'd7})) u_mux (.a_i(a_r[4:0]), .b_i(b_r[2:0]), .key_i(key_r), .y_o(y10));
  // negated mux: m = 2 - 0 - 3 = -1
  fxp_op_unit #(.OPCODE(-6), .A_S(0), .A_I(2), .A_F(2), .B_S(1), .B_I(2), .B_F(0),
    .OUT_W(6), .MUX_CFG({32'hFFFF_FFFD, 32'd5})) u_nmux (.a_i(a_r[3:0]), .b_i(b_r[2:0]), .key_i(key_r), .y_o(y11));
  fxp_op_unit #(.OPCODE(6), .A_S(0), .A_I(0), .A_F(0), .B_S(1), .B_I(3), .B_F(0),
    .OUT_W(5)) u_zmux (.a_i(a_r[0]), .b_i(b_r[3:0]), .key_i(key_r), .y_o(y12));
  fxp_op_unit #(.OPCODE(7), .A_S(1), .A_I(3), .A_F(0), .B_S(0), .B_I(3), .B_F(0),
    .OUT_W(7)) u_mul (.a_i(a_r[3:0]), .b_i(b_r[2:0]), .key_i(key_r), .y_o(y13));
  fxp_op_unit #(.OPCODE(7), .A_S(1), .A_I(2), .A_F(1), .B_S(1), .B_I(2), .B_F(0),
    .OUT_W(5)) u_mul2 (.a_i(a_r[3:0]), .b_i(b_r[2:0]), .key_i(key_r), .y_o(y14));

  function automatic longint sv(input logic [7:0] v, input int w, input bit s);
    longint r = 0;
    for (int i = 0; i < w; i++) if (v[i]) r = r + (64'sd1 <<< i);
    if (s && v[w-1]) r = r - (64'sd1 <<< w);
    return r;
  endfunction

  function automatic logic [31:0] md(input longint x, input int w);
    return 32'(x & ((64'sd1 <<< w) - 1));
  endfunction

  function automatic string rtag(input int id);
    case (id)
      0: return "R1";  1: return "R2";  2: return "R3";  3, 4: return "R4";
      5, 6: return "R5";  7, 8: return "R6";  9: return "R7";  10: return "R8";
      11: return "R9";  12: return "R10";  default: return "R11";
    endcase
  endfunction

  function automatic logic [31:0] exp_of(input int id, input logic [7:0] a,
                                         input logic [7:0] b, input logic k);
    longint x, y, n;
    case (id)
      0:  begin x = sv(a, 6, 1); y = sv(b, 4, 1); return md(x + y * 4, 9); end      // R1
      1:  begin x = sv(a, 4, 0); y = sv(b, 5, 1); return md(x * 4 - y, 8); end      // R2
      2:  begin x = sv(a, 8, 1); return (x < 0) ? 32'd0 : md(x >>> 2, 5); end       // R3
      3:  begin x = sv(a, 4, 1); return md(x >>> 1, 6); end                         // R4
      4:  begin x = sv(a, 3, 0); return md(x * 4, 6); end                           // R4
      5:  begin n = -sv(a, 6, 1); return (n < 0) ? 32'd0 : md(n >>> 1, 4); end      // R5
      6:  begin n = -sv(a, 4, 1); return md(n, 5); end                              // R5
      7:  begin x = sv(a, 5, 1); return md(x - 10, 7); end                          // R6
      8:  begin x = sv(a, 4, 0); return md(x * 4 + 3, 8); end                       // R6
      9:  return md(-3, 6);                                                         // R7
      10: begin x = sv(a, 5, 1); y = sv(b, 3, 0); return k ? md(x, 8) : md(y * 4, 8); end   // R8
      11: begin x = sv(a, 4, 0); y = sv(b, 3, 1); return k ? md(x * 2, 6) : md(-y, 6); end  // R9
      12: begin y = sv(b, 4, 1); return k ? 32'd0 : md(y, 5); end                   // R10
      13: begin x = sv(a, 4, 1); y = sv(b, 3, 0); return md(x * y, 7); end          // R11
      default: begin x = sv(a, 4, 1); y = sv(b, 3, 1); return md(x * y, 5); end     // R11
    endcase
  endfunction

  function automatic logic [31:0] act_of(input int id);
    case (id)
      0: return 32'(y0);   1: return 32'(y1);   2: return 32'(y2);   3: return 32'(y3);
      4: return 32'(y4);   5: return 32'(y5);   6: return 32'(y6);   7: return 32'(y7);
      8: return 32'(y8);   9: return 32'(y9);   10: return 32'(y10); 11: return 32'(y11);
      12: return 32'(y12); 13: return 32'(y13); default: return 32'(y14);
    endcase
  endfunction

  task automatic apply(input logic [7:0] a, input logic [7:0] b, input logic k);
    item_t it;
    @(posedge clk);
    #1;
    a_r = a; b_r = b; key_r = k;
    for (int id = 0; id < NID; id++) begin
      it.id = id; it.exp = exp_of(id, a, b, k); it.a = a; it.b = b; it.k = k;
      sb_q.push_back(it);
    end
  endtask

  // monitor: compare queued expectations once inputs have settled
  always @(negedge clk) begin
    item_t it;
    logic [31:0] act;
    while (sb_q.size() > 0) begin
      it  = sb_q.pop_front();
      act = act_of(it.id);
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s id=%0d a=%h b=%h k=%b actual=%h expected=%h",
                 rtag(it.id), it.id, it.a, it.b, it.k, act, it.exp);
      end
    end
  end

  initial begin
    logic [7:0] corner [5];
    corner = '{8'h00, 8'hFF, 8'h80, 8'h7F, 8'h01};
    @(negedge clk);
    // R7: constant present before any stimulus
    total++;
    if (y9 !== 6'd61) begin
      bad++;
      $display("FAIL R7 initial constant actual=%h expected=%h", y9, 6'd61);
    end
    for (int i = 0; i < 5; i++)
      for (int j = 0; j < 5; j++)
        for (int k = 0; k < 2; k++) apply(corner[i], corner[j], k[0]);
    // sign-bit-only codes per operand width
    apply(8'h20, 8'h08, 1'b0);   // R5: most negative 6-bit, R1 min b
    apply(8'h08, 8'h04, 1'b1);   // R4/R5: 4-bit minimum
    apply(8'h10, 8'h04, 1'b0);   // R6/R8/R9
    for (int n = 0; n < 400; n++) apply(8'($urandom), 8'($urandom), 1'($urandom));
    repeat (2) @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(2 * HALF * 20000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule